// File: doc/BRIEF.md
# Delayed-Branch Program Counter and Trap Sequencer

This block produces the fetch address for a 32-bit front end whose control transfers take effect one instruction late. When decode and execute report that the instruction at the current address has completed, the block advances the address. If that instruction was a taken branch, the block first steps to the following address, the delay slot. It redirects to the held target only once the slot instruction has completed.

A trap request stops the current instruction and forces the handler vector. The block records a return address, the trap code and a flag that says whether the trapped instruction sat in a delay slot. When the slot was hit, the return address is that of the branch before the slot. A return strobe then reloads that address, so the branch runs again and its slot and target are not lost. All pins are plain control and status signals: the instruction-complete strobe is the only pacing input, and the fetch address holds whenever it is low.

Top module: `pcs_top`

## Requirements
- R1: During and after reset, `fetch_pc` is 0xBFC00000, `epc` is 0, `cause` is 0 and `in_slot` is 0.
- R2: When `instr_done` is high with no branch, trap, return or pending slot, `fetch_pc` rises by 4 on the next cycle. When `instr_done` is low and there is no trap or return, `fetch_pc` holds.
- R3: `instr_done` and `br_taken` together, outside a slot, move `fetch_pc` to the current address plus 4 on the next cycle, set `in_slot` and hold `br_target`.
- R4: `instr_done` while `in_slot` is high moves `fetch_pc` to the held target on the next cycle and clears `in_slot`.
- R5: A trap (`trap_req`) while `in_slot` is high sets `epc` to `fetch_pc` minus 4 and sets `cause` bit 31.
- R6: A trap while `in_slot` is low sets `epc` to `fetch_pc` and clears `cause` bit 31.
- R7: On any trap, `cause` bits 6:2 take `trap_code`, every other `cause` bit except bit 31 reads 0, `fetch_pc` becomes 0x80000180 and `in_slot` clears.
- R8: `trap_ret` without a trap loads `fetch_pc` from `epc` and clears `in_slot`. A branch reached this way sets up its slot and target again.
- R9: A trap wins over `br_taken`, `instr_done` and `trap_ret` in the same cycle. The branch is not recorded, so `in_slot` reads 0 afterwards.
- R10: `br_taken` is ignored when `instr_done` is low, and also when `in_slot` is high. In the second case the slot completes toward the first target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Instruction at `fetch_pc` completed this cycle |
| br_taken | input | 1 | The completing instruction is a taken branch |
| br_target | input | 32 | Branch destination address |
| trap_req | input | 1 | Exception or interrupt on the instruction at `fetch_pc` |
| trap_code | input | 5 | Trap reason code |
| trap_ret | input | 1 | Return from the trap handler |
| fetch_pc | output | 32 | Current fetch address |
| epc | output | 32 | Saved return address |
| cause | output | 32 | Bit 31 is the delay flag, bits 6:2 the code |
| in_slot | output | 1 | The instruction at `fetch_pc` is a delay slot |

## Verification
The hardest state to reach from the ports is a trap landing exactly on a delay-slot instruction. After that, the return must replay the branch so that the slot and the target are fetched again in order. The bench reaches this state by sweeping where a branch sits in a run of sequential instructions. It injects the trap before the branch, on the slot and on the target, and at every one of the 32 codes. Each of these runs is followed by a return and the rest of the replayed sequence, with an arithmetic model that tracks the expected address, return address and flag.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Per-cycle action chosen by the arbiter, highest priority first in decode.
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_SEQ,
    ACT_TAKE,
    ACT_SLOT_DONE,
    ACT_TRAP,
    ACT_RETURN
  } pcs_act_e;
endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pcs_pkg::*;
(
  input  logic     instr_done,
  input  logic     br_taken,
  input  logic     trap_req,
  input  logic     trap_ret,
  input  logic     pending,
  output pcs_act_e act
);
  always_comb begin
    if (trap_req)            act = ACT_TRAP;
    else if (trap_ret)       act = ACT_RETURN;
    else if (!instr_done)    act = ACT_HOLD;
    else if (pending)        act = ACT_SLOT_DONE;
    else if (br_taken)       act = ACT_TAKE;
    else                     act = ACT_SEQ;
  end
endmodule

// File: rtl/pcs_slot_tracker.sv
module pcs_slot_tracker
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pcs_act_e        act,
  input  logic [XLEN-1:0] br_target,
  output logic            pending,
  output logic [XLEN-1:0] target
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      target  <= '0;
    end else begin
      unique case (act)
        ACT_TAKE: begin
          pending <= 1'b1;
          target  <= br_target;
        end
        ACT_SLOT_DONE, ACT_TRAP, ACT_RETURN: pending <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcs_trap_capture.sv
module pcs_trap_capture
  import pcs_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcs_act_e          act,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   pc,
  input  logic              pending,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause
);
  localparam int CODE_LO = 2;
  localparam int CODE_HI = CODE_LO + CODE_W - 1;
  localparam int BD_BIT  = XLEN - 1;

  logic [XLEN-1:0] cause_next;

  always_comb begin
    cause_next = '0;
    cause_next[CODE_HI:CODE_LO] = trap_code;
    cause_next[BD_BIT] = pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else if (act == ACT_TRAP) begin
      epc   <= pending ? pc - XLEN'(STEP) : pc;
      cause <= cause_next;
    end
  end
endmodule

// File: rtl/pcs_top.sv
module pcs_top
  import pcs_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          CODE_W      = 5,
  parameter int          STEP        = 4,
  parameter logic [31:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              br_taken,
  input  logic [XLEN-1:0]   br_target,
  input  logic              trap_req,
  input  logic [CODE_W-1:0] trap_code,
  input  logic              trap_ret,
  output logic [XLEN-1:0]   fetch_pc,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause,
  output logic              in_slot
);
  pcs_act_e        act;
  logic            pending;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] pc_q, pc_d;

  pcs_arbiter u_arb (
    .instr_done (instr_done),
    .br_taken   (br_taken),
    .trap_req   (trap_req),
    .trap_ret   (trap_ret),
    .pending    (pending),
    .act        (act)
  );

  pcs_slot_tracker #(.XLEN(XLEN)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .br_target (br_target),
    .pending   (pending),
    .target    (target)
  );

  pcs_trap_capture #(.XLEN(XLEN), .CODE_W(CODE_W), .STEP(STEP)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .trap_code (trap_code),
    .pc        (pc_q),
    .pending   (pending),
    .epc       (epc),
    .cause     (cause)
  );

  always_comb begin
    unique case (act)
      ACT_TRAP:      pc_d = XLEN'(HANDLER_VEC);
      ACT_RETURN:    pc_d = epc;
      ACT_SLOT_DONE: pc_d = target;
      ACT_TAKE,
      ACT_SEQ:       pc_d = pc_q + XLEN'(STEP);
      default:       pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= XLEN'(RESET_VEC);
    else        pc_q <= pc_d;
  end

  assign fetch_pc = pc_q;
  assign in_slot  = pending;
endmodule

// File: rtl/pcs_top_chk.sv
module pcs_top_chk #(
  parameter int          XLEN        = 32,
  parameter logic [31:0] HANDLER_VEC = 32'h8000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_done,
  input logic            br_taken,
  input logic            trap_req,
  input logic            trap_ret,
  input logic [XLEN-1:0] fetch_pc,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] cause,
  input logic            in_slot
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_done && !trap_req && !trap_ret) |=> $stable(fetch_pc));
  // R3
  take_enters_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && br_taken && !in_slot && !trap_req && !trap_ret)
      |=> (in_slot && fetch_pc == $past(fetch_pc) + 32'd4));
  // R5
  slot_trap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && in_slot) |=> (cause[XLEN-1] && epc == $past(fetch_pc) - 32'd4));
  // R6
  plain_trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !in_slot) |=> (!cause[XLEN-1] && epc == $past(fetch_pc)));
  // R7 R9
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (fetch_pc == XLEN'(HANDLER_VEC) && !in_slot));
  // R8
  return_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !trap_req) |=> (fetch_pc == $past(epc) && !in_slot));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (cause == '0 && !in_slot));
endmodule

bind pcs_top pcs_top_chk #(.XLEN(XLEN), .HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_done (instr_done),
  .br_taken   (br_taken),
  .trap_req   (trap_req),
  .trap_ret   (trap_ret),
  .fetch_pc   (fetch_pc),
  .epc        (epc),
  .cause      (cause),
  .in_slot    (in_slot)
);

// File: tb/pcs_top_test.sv
`timescale 1ns/1ps
module pcs_top_test;
  localparam logic [31:0] RV = 32'hBFC0_0000;
  localparam logic [31:0] HV = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_done, br_taken, trap_req, trap_ret;
  logic [31:0] br_target;
  logic [4:0]  trap_code;
  logic [31:0] fetch_pc, epc, cause;
  logic        in_slot;

  int n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  // bench model state
  logic [31:0] m_pc, m_epc, m_cause, m_tgt;
  logic        m_slot;

  always #2 clk = ~clk;

  pcs_top uut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .br_taken(br_taken),
    .br_target(br_target), .trap_req(trap_req), .trap_code(trap_code),
    .trap_ret(trap_ret), .fetch_pc(fetch_pc), .epc(epc), .cause(cause),
    .in_slot(in_slot)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "fetch_pc", fetch_pc, m_pc);
    chk(tag, "epc", epc, m_epc);
    chk(tag, "cause", cause, m_cause);
    chk(tag, "in_slot", {31'd0, in_slot}, {31'd0, m_slot});
  endtask

  // One cycle: drive on the falling edge, model the rising edge, compare after it.
  task automatic step(input logic v, input logic b, input logic [31:0] t,
                      input logic e, input logic [4:0] c, input logic r,
                      input string tag);
    @(negedge clk);
    instr_done = v; br_taken = b; br_target = t;
    trap_req = e; trap_code = c; trap_ret = r;
    if (e) begin
      m_epc   = m_slot ? m_pc - 32'd4 : m_pc;
      m_cause = {m_slot, 24'd0, c, 2'b00};
      m_slot  = 1'b0;
      m_pc    = HV;
    end else if (r) begin
      m_pc = m_epc; m_slot = 1'b0;
    end else if (v) begin
      if (m_slot) begin m_pc = m_tgt; m_slot = 1'b0; end
      else if (b) begin m_tgt = t; m_slot = 1'b1; m_pc = m_pc + 32'd4; end
      else m_pc = m_pc + 32'd4;
    end
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_done = 0; br_taken = 0; br_target = '0;
    trap_req = 0; trap_code = '0; trap_ret = 0;
    @(posedge clk); @(posedge clk);
    #1;
    m_pc = RV; m_epc = '0; m_cause = '0; m_slot = 1'b0; m_tgt = '0;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();

    // Directed: the worked trap-in-slot sequence
    step(1, 0, 0, 0, 0, 0, "R2");                    // BFC00000 -> 04
    step(0, 0, 0, 0, 0, 0, "R2");                    // hold
    step(1, 1, 32'h0000_0100, 0, 0, 0, "R3");        // branch at 04 -> slot 08
    step(1, 1, 32'h0000_0800, 0, 0, 0, "R10");       // branch in slot ignored -> 100
    chk("R4", "target", fetch_pc, 32'h0000_0100);
    step(1, 1, 32'h0000_0200, 0, 0, 0, "R3");        // 100 -> 104 slot
    step(0, 0, 0, 1, 5'd0, 0, "R5");                 // interrupt in slot
    chk("R5", "epc", epc, 32'h0000_0100);
    chk("R5", "bd", {31'd0, cause[31]}, 32'd1);
    step(0, 0, 0, 0, 0, 1, "R8");                    // return to branch
    chk("R8", "replay", fetch_pc, 32'h0000_0100);
    step(1, 1, 32'h0000_0200, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, "R8");
    chk("R8", "target", fetch_pc, 32'h0000_0200);
    step(0, 1, 32'h0000_0300, 0, 0, 0, "R10");       // branch without done ignored
    step(1, 1, 32'h0000_0300, 1, 5'd9, 1, "R9");     // trap beats branch and return
    chk("R9", "no slot", {31'd0, in_slot}, 32'd0);
    step(1, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 5'd31, 0, "R6");
    chk("R7", "code", {27'd0, cause[6:2]}, 32'd31);

    // Sweep: branch position, trap placement, every code
    for (int c = 0; c < 32; c++) begin
      for (int pos = 0; pos < 3; pos++) begin
        for (int gap = 0; gap < 3; gap++) begin
          do_reset();
          for (int k = 0; k < gap; k++) step(1, 0, 0, 0, 0, 0, "R2");
          if (pos == 0) step(0, 0, 0, 1, 5'(c), 0, "R6");
          step(1, 1, 32'h0000_1000 + 32'(c * 64), 0, 0, 0, "R3");
          if (pos == 1) step(0, 0, 0, 1, 5'(c), 0, "R5");
          if (pos != 1) step(1, 0, 0, 0, 0, 0, "R4");
          if (pos == 2) step(0, 0, 0, 1, 5'(c), 0, "R7");
          step(0, 0, 0, 0, 0, 1, "R8");
          step(1, 1, 32'h0000_2000, 0, 0, 0, "R8");
          step(1, 0, 0, 0, 0, 0, "R4");
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule